// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces the processor reset for a supervisory power-monitoring subsystem. It takes three reset causes. The first two are comparator flags from analog circuitry: a low-line flag and a flag that says the supply has dropped under the backup battery. These two flags arrive asynchronously and are resynchronized inside the block. The third cause is a synchronous fault request from the watchdog.

The block holds reset asserted while either flag is set. After both flags clear, it keeps reset asserted for a fixed number of timebase ticks. The timebase is a shared clock-enable at about 10.24 kHz, so the default of 512 ticks gives roughly 50 ms. A watchdog request produces a reset pulse of the same width.

The block has several outputs besides the reset:
- An active-high copy of the reset.
- A low-line status line.
- A chip-enable output that blocks RAM writes while the supply is not valid.
- A one-cycle release strobe, which tells the watchdog that reset has ended.

Top module: `sup_reset_gen`

## Requirements
- R1: While the synchronized low-line flag or the synchronized supply-below-battery flag is 1, `cpu_rst_n` is 0. An input change becomes visible on the outputs after SYNC_STAGES (default 2) rising clock edges.
- R2: After both synchronized flags read 0, `cpu_rst_n` stays 0 for exactly HOLD_TICKS (default 512) clock edges on which `tick_en` is 1. It rises right after the edge that counts the last of these ticks.
- R3: When reset is deasserted, a `wdog_trip` pulse sampled at a clock edge drives `cpu_rst_n` to 0 from that edge onward. The pulse lasts HOLD_TICKS ticks, and ticks sampled at later edges are the ones counted.
- R4: `cpu_rst` is always the bitwise inverse of `cpu_rst_n`.
- R5: `lowline_n` is 0 while the synchronized low-line flag is 1 and is 1 once it is 0 again, with no hold-off.
- R6: `cen_out` (active low) equals `cen_in` while both synchronized flags are 0. It is forced to 1 while either flag is 1.
- R7: While the synchronized supply-below-battery flag is 1, the outputs are `cpu_rst_n`=0, `cpu_rst`=1, `lowline_n`=0 and `cen_out`=1.
- R8: If a flag sets again while the hold-off is counting, the count is discarded. The full HOLD_TICKS count restarts after the flags clear.
- R9: A `wdog_trip` pulse that arrives while reset is already asserted does not lengthen or restart the pulse.
- R10: `rst_release` is 1 for exactly one cycle: the cycle in which `cpu_rst_n` has just risen. This holds whatever caused the reset.
- R11: While `arst_n` is 0, and for HOLD_TICKS ticks after it is released, `cpu_rst_n` is 0. This gives a power-up reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous system reset, active low |
| tick_en | input | 1 | Timebase clock-enable, one cycle per tick |
| lowline_raw | input | 1 | Asynchronous low-line comparator flag, 1 = low |
| onbatt_raw | input | 1 | Asynchronous flag, 1 = supply below battery |
| wdog_trip | input | 1 | Synchronous watchdog fault request |
| cen_in | input | 1 | Chip-enable from the processor, active low |
| cpu_rst_n | output | 1 | Processor reset, active low |
| cpu_rst | output | 1 | Processor reset, active high |
| lowline_n | output | 1 | Low-line status, 0 = low supply |
| cen_out | output | 1 | Gated chip-enable to RAM, active low |
| rst_release | output | 1 | One-cycle end-of-reset strobe to the watchdog |

## Verification
The timing of each output is as follows:
- A flag change reaches `lowline_n`, `cen_out` and the reset outputs after two clock edges of synchronization.
- A watchdog request acts after one edge.
- `cen_in` passes through with no clock delay.
- Reset release follows the edge that samples the last counted tick, and `rst_release` is high in that same cycle.

The bench drives inputs on the falling edge and samples every output one time unit before the next rising edge, so every registered value has settled. A behavioural model advances on the same rising edges and gives the expected value of every output on every cycle. A separate tick counter measures each reset pulse width directly in timebase ticks.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;
   typedef enum logic {
      HOLD_IDLE = 1'b0,
      HOLD_RUN  = 1'b1
   } hold_state_e;
endpackage

// File: rtl/sup_flag_sync.sv
module sup_flag_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 0) begin : g_bad
         $error("sup_flag_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain_q <= '0;
            else         chain_q <= {chain_q[STAGES-2+((STAGES==1)?1:0):0], d};
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sup_holdoff.sv
module sup_holdoff
   import sup_rst_pkg::*;
#(
   parameter int HOLD_TICKS = 512
) (
   input  logic clk,
   input  logic arst_n,
   input  logic tick_en,
   input  logic fault,
   input  logic wd_req,
   output logic asserted,
   output logic release_stb
);
   localparam int CW = (HOLD_TICKS > 2) ? $clog2(HOLD_TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

   generate
      if (HOLD_TICKS < 2) begin : g_bad
         $error("sup_holdoff: HOLD_TICKS must be at least 2");
      end
   endgenerate

   hold_state_e   state_q;
   logic [CW-1:0] cnt_q;
   logic          prev_q;

   assign asserted    = fault | (state_q == HOLD_RUN);
   assign release_stb = prev_q & ~asserted;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         state_q <= HOLD_RUN;
         cnt_q   <= '0;
         prev_q  <= 1'b1;
      end else begin
         prev_q <= asserted;
         if (fault) begin
            state_q <= HOLD_RUN;
            cnt_q   <= '0;
         end else if (wd_req && !asserted) begin
            state_q <= HOLD_RUN;
            cnt_q   <= '0;
         end else if (state_q == HOLD_RUN && tick_en) begin
            if (cnt_q == LAST) begin
               state_q <= HOLD_IDLE;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!arst_n)
      cnt_q <= LAST);
   a_r8_restart: assert property (@(posedge clk) disable iff (!arst_n)
      fault |=> (cnt_q == '0) && asserted);
   a_r9_wd_no_restart: assert property (@(posedge clk) disable iff (!arst_n)
      (asserted && !fault && wd_req && !tick_en) |=> $stable(cnt_q));
   a_r10_single_strobe: assert property (@(posedge clk) disable iff (!arst_n)
      release_stb |=> !release_stb);
   a_r3_wd_starts: assert property (@(posedge clk) disable iff (!arst_n)
      (wd_req && !asserted) |=> asserted);
endmodule

// File: rtl/sup_out_gate.sv
module sup_out_gate (
   input  logic lowline_s,
   input  logic onbatt_s,
   input  logic asserted,
   input  logic cen_in,
   output logic cpu_rst_n,
   output logic cpu_rst,
   output logic lowline_n,
   output logic cen_out
);
   logic bad_supply;
   assign bad_supply = lowline_s | onbatt_s;
   assign cpu_rst_n  = ~asserted;
   assign cpu_rst    = asserted;
   assign lowline_n  = ~bad_supply;
   assign cen_out    = cen_in | bad_supply;
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
   parameter int HOLD_TICKS  = 512,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic tick_en,
   input  logic lowline_raw,
   input  logic onbatt_raw,
   input  logic wdog_trip,
   input  logic cen_in,
   output logic cpu_rst_n,
   output logic cpu_rst,
   output logic lowline_n,
   output logic cen_out,
   output logic rst_release
);
   logic lowline_s, onbatt_s, asserted;

   sup_flag_sync #(.STAGES(SYNC_STAGES)) u_sync_ll (
      .clk(clk), .arst_n(arst_n), .d(lowline_raw), .q(lowline_s));
   sup_flag_sync #(.STAGES(SYNC_STAGES)) u_sync_bat (
      .clk(clk), .arst_n(arst_n), .d(onbatt_raw), .q(onbatt_s));

   sup_holdoff #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
      .clk(clk), .arst_n(arst_n), .tick_en(tick_en),
      .fault(lowline_s | onbatt_s), .wd_req(wdog_trip),
      .asserted(asserted), .release_stb(rst_release));

   sup_out_gate u_gate (
      .lowline_s(lowline_s), .onbatt_s(onbatt_s), .asserted(asserted),
      .cen_in(cen_in), .cpu_rst_n(cpu_rst_n), .cpu_rst(cpu_rst),
      .lowline_n(lowline_n), .cen_out(cen_out));

   a_r4_inverse: assert property (@(posedge clk) disable iff (!arst_n)
      cpu_rst == !cpu_rst_n);
   a_r1_flag_holds_reset: assert property (@(posedge clk) disable iff (!arst_n)
      (lowline_s || onbatt_s) |-> !cpu_rst_n);
   a_r6_ce_blocked: assert property (@(posedge clk) disable iff (!arst_n)
      (lowline_s || onbatt_s) |-> cen_out);
   a_r7_battery_outputs: assert property (@(posedge clk) disable iff (!arst_n)
      onbatt_s |-> (!cpu_rst_n && !lowline_n && cen_out));
   a_r10_release_edge: assert property (@(posedge clk) disable iff (!arst_n)
      rst_release |-> cpu_rst_n);
endmodule

// File: tb/tb_sup_reset_gen.sv
module tb_sup_reset_gen;
   localparam int HOLD = 512;

   logic clk = 1'b0, arst_n = 1'b0, tick_en = 1'b0;
   logic lowline_raw = 1'b0, onbatt_raw = 1'b0, wdog_trip = 1'b0, cen_in = 1'b1;
   logic cpu_rst_n, cpu_rst, lowline_n, cen_out, rst_release;

   int checks = 0, errors = 0;
   bit compare_on = 1'b0, finished = 1'b0;

   always #5 clk = ~clk;

   sup_reset_gen #(.HOLD_TICKS(HOLD), .SYNC_STAGES(2)) dut (
      .clk(clk), .arst_n(arst_n), .tick_en(tick_en), .lowline_raw(lowline_raw),
      .onbatt_raw(onbatt_raw), .wdog_trip(wdog_trip), .cen_in(cen_in),
      .cpu_rst_n(cpu_rst_n), .cpu_rst(cpu_rst), .lowline_n(lowline_n),
      .cen_out(cen_out), .rst_release(rst_release));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int  m_ll1, m_ll2, m_bt1, m_bt2, m_cnt, m_hold, m_prev;
   always @(posedge clk) begin
      int fault, asrt;
      if (!arst_n) begin
         m_ll1 = 0; m_ll2 = 0; m_bt1 = 0; m_bt2 = 0;
         m_hold = 1; m_cnt = 0; m_prev = 1;
      end else begin
         fault = m_ll2 | m_bt2;
         asrt  = fault | m_hold;
         m_prev = asrt;
         if (fault) begin m_hold = 1; m_cnt = 0; end
         else if (wdog_trip && !asrt) begin m_hold = 1; m_cnt = 0; end
         else if (m_hold && tick_en) begin
            if (m_cnt == HOLD - 1) begin m_hold = 0; m_cnt = 0; end
            else m_cnt++;
         end
         m_ll2 = m_ll1; m_ll1 = int'(lowline_raw);
         m_bt2 = m_bt1; m_bt1 = int'(onbatt_raw);
      end
   end

   // per-cycle comparison, sampled one unit before each rising edge
   int  width_ticks = 0;
   bit  was_low = 1'b0;
   always @(negedge clk) begin
      int fault, asrt, e_done;
      #4;
      if (compare_on) begin
         fault  = m_ll2 | m_bt2;
         asrt   = fault | m_hold;
         e_done = m_prev & ~asrt;
         chk(int'(cpu_rst_n) == 1 - asrt, "R1 R2 R3 cpu_rst_n", int'(cpu_rst_n), 1 - asrt);
         chk(cpu_rst == ~cpu_rst_n, "R4 cpu_rst inverse", int'(cpu_rst), int'(~cpu_rst_n));
         chk(int'(lowline_n) == 1 - fault, "R5 lowline_n", int'(lowline_n), 1 - fault);
         chk(int'(cen_out) == (fault | int'(cen_in)), "R6 cen_out", int'(cen_out),
             fault | int'(cen_in));
         chk(int'(rst_release) == e_done, "R10 rst_release", int'(rst_release), e_done);
         // direct width measurement in ticks
         if (cpu_rst_n && was_low)
            chk(width_ticks == HOLD, "R2 R3 R8 R9 R11 pulse width", width_ticks, HOLD);
         if (fault || cpu_rst_n) width_ticks = 0;
         else if (tick_en) width_ticks++;
         was_low = !cpu_rst_n;
      end
   end

   // timebase
   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         ph++;
         tick_en = (ph % 4 == 0);
      end
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_release();
      int guard = 0;
      while (!cpu_rst_n && guard < 4 * HOLD * 4 + 100) begin
         @(negedge clk); #4; guard++;
      end
      chk(cpu_rst_n == 1'b1, "R2 release reached", int'(cpu_rst_n), 1);
      @(negedge clk);
   endtask

   initial begin
      cyc(3);
      #4;
      chk(cpu_rst_n == 1'b0 && rst_release == 1'b0, "R11 reset state", int'(cpu_rst_n), 0);
      @(negedge clk);
      arst_n = 1'b1;
      compare_on = 1'b1;
      wait_release();                      // R11 power-up pulse
      for (int i = 0; i < 6; i++) begin    // R6 pass-through
         cen_in = i[0];
         @(negedge clk); #1;
         chk(cen_out == cen_in, "R6 pass-through", int'(cen_out), int'(cen_in));
      end
      cen_in = 1'b0;
      lowline_raw = 1'b1;                  // R1 R5
      cyc(1); #4;
      chk(cpu_rst_n == 1'b1, "R1 not yet synced", int'(cpu_rst_n), 1);
      cyc(1); #4;
      chk(cpu_rst_n == 1'b0 && lowline_n == 1'b0, "R1 R5 after two edges",
          int'(cpu_rst_n), 0);
      cyc(20);
      lowline_raw = 1'b0;
      cyc(3); #4;
      chk(lowline_n == 1'b1 && cpu_rst_n == 1'b0, "R5 R2 lowline clears, hold continues",
          int'(lowline_n), 1);
      cyc(900);
      lowline_raw = 1'b1;                  // R8 restart mid-count
      cyc(5);
      lowline_raw = 1'b0;
      wait_release();
      onbatt_raw = 1'b1;                   // R7
      cyc(3); #4;
      chk(!cpu_rst_n && cpu_rst && !lowline_n && cen_out, "R7 battery outputs",
          {cpu_rst_n, cpu_rst, lowline_n, cen_out}, 4'b0101);
      cyc(40);
      onbatt_raw = 1'b0;
      wait_release();
      cyc(10);
      wdog_trip = 1'b1;                    // R3
      @(negedge clk); wdog_trip = 1'b0; #4;
      chk(cpu_rst_n == 1'b0, "R3 watchdog starts pulse", int'(cpu_rst_n), 1'b0);
      cyc(1000);
      wdog_trip = 1'b1;                    // R9 ignored during reset
      cyc(3);
      wdog_trip = 1'b0;
      wait_release();
      lowline_raw = 1'b1;                  // short glitch
      cyc(1);
      lowline_raw = 1'b0;
      wait_release();
      cyc(20);
      finished = 1'b1;
   end

   initial begin
      int n = 0;
      while (!finished && n < 150000) begin @(posedge clk); n++; end
      if (!finished) chk(1'b0, "watchdog timeout", n, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule